// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several requesting agents share one small word-addressed memory and build atomic read-modify-write sequences on it. A load-linked access reads a word and records a reservation for that agent on that address. A later store-conditional from the same agent commits its data only when no other agent has stored to that address in the meantime. It returns a success flag that software tests to decide whether to retry. Plain reads and plain stores are also supported. Every store that commits is snooped against all reservations, so a conflicting store cancels the reservations of the other agents.

Each agent drives a request with a valid bit, a 2-bit operation code, an address and write data. A fixed-priority arbiter picks one requester per cycle. The granted access is performed at the next clock edge. The response, which carries the agent index, the word read, the success flag and a write-commit strobe, appears in the cycle after the grant. A requester whose request is not granted keeps it asserted until it is.

Top module: `llsc_monitor`

## Requirements
- R1: At most one agent is granted per cycle, only an agent whose request is valid is granted, and some agent is always granted while any request is valid. With the default priority, the lowest-numbered valid agent wins.
- R2: A grant in one cycle produces rsp_valid in the next cycle, with rsp_agent equal to the granted index. A cycle with no grant produces no response in the next cycle.
- R3: Operation code 2 (load-linked) returns the addressed word on rsp_rdata and records a valid reservation for that agent on that address.
- R4: Operation code 0 (read) returns the addressed word without writing. Operation code 1 (plain store) writes req_wdata and pulses mem_wr_fire. For every operation, rsp_rdata is the word held before the access.
- R5: Operation code 3 (store-conditional) from an agent whose valid reservation matches the address writes the data, sets rsp_sc_ok to 1 and pulses mem_wr_fire.
- R6: A committed store (a plain store, or a successful store-conditional) to an address clears the reservation of every other agent on that address. Their later store-conditional to that address then fails.
- R7: A failed store-conditional leaves the memory unchanged, returns rsp_sc_ok 0 and gives no mem_wr_fire pulse.
- R8: A store-conditional fails when the agent holds no reservation, or holds one on a different address.
- R9: An agent's store-conditional clears its own reservation whether it succeeds or fails, so a second store-conditional without a new load-linked fails.
- R10: A new load-linked replaces the agent's earlier reservation. Only the latest address stays reserved.
- R11: Reads, load-linked accesses, stores to other addresses and the agent's own plain stores leave a reservation in place.
- R12: After reset all memory words read as zero, no agent holds a reservation, and rsp_valid is 0.
- R13: rsp_sc_ok is 1 only in response to a store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_AGENTS | Request valid, one bit per agent |
| req_op | input | 2*N_AGENTS | Operation code per agent: 0 read, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W*N_AGENTS | Word address per agent |
| req_wdata | input | DATA_W*N_AGENTS | Write data per agent |
| req_grant | output | N_AGENTS | One-hot grant, combinational from req_valid |
| rsp_valid | output | 1 | Response present for the access granted in the previous cycle |
| rsp_agent | output | AGT_W | Index of the agent being answered |
| rsp_rdata | output | DATA_W | Word held at the address before the access |
| rsp_sc_ok | output | 1 | Store-conditional success flag |
| mem_wr_fire | output | 1 | A write was committed by the answered access |

## Verification
The assertions assume that every request field is at a known value whenever its valid bit is set, and that the operation code uses only its four defined values. The bench drives all request fields to defined values from reset onward and changes them only on the falling clock edge. The checker rebuilds the granted operation from the port values, and so it also depends on the request fields being stable during the grant cycle. The bench therefore holds each request for the whole cycle in which it is granted.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_STORE = 2'd1,
      OP_LLOAD = 2'd2,
      OP_CSTOR = 2'd3
   } llsc_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
   parameter int N_AGENTS  = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N_AGENTS-1:0] req,
   output logic [N_AGENTS-1:0] gnt
);
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            gnt = '0;
            for (int i = N_AGENTS - 1; i >= 0; i--) begin
               if (req[i]) begin
                  gnt = '0;
                  gnt[i] = 1'b1;
               end
            end
         end
      end else begin : g_high
         always_comb begin
            gnt = '0;
            for (int i = 0; i < N_AGENTS; i++) begin
               if (req[i]) begin
                  gnt = '0;
                  gnt[i] = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               words[w] <= '0;
            end else if (we && addr == ADDR_W'(w)) begin
               words[w] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = words[addr];
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
   parameter int N_AGENTS = 4,
   parameter int ADDR_W   = 4,
   localparam int AGT_W   = $clog2(N_AGENTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ll_en,
   input  logic              sc_en,
   input  logic              wr_commit,
   input  logic [AGT_W-1:0]  agent,
   input  logic [ADDR_W-1:0] addr,
   output logic              sc_hit
);
   logic [N_AGENTS-1:0] rv;
   logic [ADDR_W-1:0]   ra [N_AGENTS];

   generate
      for (genvar i = 0; i < N_AGENTS; i++) begin : g_slot
         logic mine;
         logic snoop_hit;
         assign mine      = (agent == AGT_W'(i));
         assign snoop_hit = wr_commit && !mine && rv[i] && (ra[i] == addr);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rv[i] <= 1'b0;
               ra[i] <= '0;
            end else if (ll_en && mine) begin
               rv[i] <= 1'b1;
               ra[i] <= addr;
            end else if (sc_en && mine) begin
               rv[i] <= 1'b0;
            end else if (snoop_hit) begin
               rv[i] <= 1'b0;
            end
         end
      end
   endgenerate

   assign sc_hit = rv[agent] && (ra[agent] == addr);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int N_AGENTS  = 4,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int AGT_W    = $clog2(N_AGENTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_AGENTS-1:0]        req_valid,
   input  logic [2*N_AGENTS-1:0]      req_op,
   input  logic [ADDR_W*N_AGENTS-1:0] req_addr,
   input  logic [DATA_W*N_AGENTS-1:0] req_wdata,
   output logic [N_AGENTS-1:0]        req_grant,
   output logic                       rsp_valid,
   output logic [AGT_W-1:0]           rsp_agent,
   output logic [DATA_W-1:0]          rsp_rdata,
   output logic                       rsp_sc_ok,
   output logic                       mem_wr_fire
);
   initial begin
      assert (N_AGENTS >= 2 && N_AGENTS <= 32)
         else $error("llsc_monitor: N_AGENTS out of range");
      assert (ADDR_W >= 1 && ADDR_W <= 10)
         else $error("llsc_monitor: ADDR_W out of range");
      assert (DATA_W >= 1)
         else $error("llsc_monitor: DATA_W out of range");
   end

   logic              any_gnt;
   logic [AGT_W-1:0]  sel;
   llsc_op_e          sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic [DATA_W-1:0] mem_q;
   logic              sc_hit;
   logic              do_ll, do_sc, do_write;

   llsc_arbiter #(.N_AGENTS(N_AGENTS), .LOW_FIRST(LOW_FIRST)) u_arb (
      .req (req_valid),
      .gnt (req_grant)
   );

   always_comb begin
      sel       = '0;
      sel_op    = OP_READ;
      sel_addr  = '0;
      sel_wdata = '0;
      for (int i = 0; i < N_AGENTS; i++) begin
         if (req_grant[i]) begin
            sel       = AGT_W'(i);
            sel_op    = llsc_op_e'(req_op[2*i +: 2]);
            sel_addr  = req_addr[ADDR_W*i +: ADDR_W];
            sel_wdata = req_wdata[DATA_W*i +: DATA_W];
         end
      end
   end

   assign any_gnt  = |req_grant;
   assign do_ll    = any_gnt && sel_op == OP_LLOAD;
   assign do_sc    = any_gnt && sel_op == OP_CSTOR;
   assign do_write = any_gnt && (sel_op == OP_STORE || (sel_op == OP_CSTOR && sc_hit));

   llsc_resv_table #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .ll_en     (do_ll),
      .sc_en     (do_sc),
      .wr_commit (do_write),
      .agent     (sel),
      .addr      (sel_addr),
      .sc_hit    (sc_hit)
   );

   llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (do_write),
      .addr  (sel_addr),
      .wdata (sel_wdata),
      .rdata (mem_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_agent   <= '0;
         rsp_rdata   <= '0;
         rsp_sc_ok   <= 1'b0;
         mem_wr_fire <= 1'b0;
      end else begin
         rsp_valid   <= any_gnt;
         rsp_agent   <= sel;
         rsp_rdata   <= mem_q;
         rsp_sc_ok   <= do_sc && sc_hit;
         mem_wr_fire <= do_write;
      end
   end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
   parameter int N_AGENTS  = 4,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int AGT_W    = $clog2(N_AGENTS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_AGENTS-1:0]        req_valid,
   input logic [2*N_AGENTS-1:0]      req_op,
   input logic [ADDR_W*N_AGENTS-1:0] req_addr,
   input logic [DATA_W*N_AGENTS-1:0] req_wdata,
   input logic [N_AGENTS-1:0]        req_grant,
   input logic                       rsp_valid,
   input logic [AGT_W-1:0]           rsp_agent,
   input logic [DATA_W-1:0]          rsp_rdata,
   input logic                       rsp_sc_ok,
   input logic                       mem_wr_fire
);
   logic [1:0] gnt_op;
   logic [1:0] last_op;

   always_comb begin
      gnt_op = 2'd0;
      for (int i = 0; i < N_AGENTS; i++) begin
         if (req_grant[i]) gnt_op = req_op[2*i +: 2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_op <= 2'd0;
      else        last_op <= gnt_op;
   end

   p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_grant));
   p_grant_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant & ~req_valid) == '0);
   p_grant_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |-> (|req_grant));
   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_grant) |=> rsp_valid);
   p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_grant) |=> !rsp_valid);
   p_read_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !last_op[0]) |-> !mem_wr_fire);
   p_store_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && last_op == 2'd1) |-> mem_wr_fire);
   p_ok_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sc_ok |-> mem_wr_fire);
   p_fail_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && last_op == 2'd3 && !rsp_sc_ok) |-> !mem_wr_fire);
   p_ok_only_sc_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sc_ok |-> (rsp_valid && last_op == 2'd3));
   p_fire_has_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_fire |-> rsp_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(
   .N_AGENTS (N_AGENTS),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LOW_FIRST(LOW_FIRST)
) u_chk (.*);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
   localparam int N  = 4;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int AGW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [2*N-1:0]  req_op = '0;
   logic [AW*N-1:0] req_addr = '0;
   logic [DW*N-1:0] req_wdata = '0;
   logic [N-1:0]    req_grant;
   logic            rsp_valid;
   logic [AGW-1:0]  rsp_agent;
   logic [DW-1:0]   rsp_rdata;
   logic            rsp_sc_ok;
   logic            mem_wr_fire;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_mem [1<<AW];
   bit            m_rv  [N];
   logic [AW-1:0] m_ra  [N];

   always #4 clk = ~clk;

   llsc_monitor u_llsc_monitor (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
      .rsp_valid(rsp_valid), .rsp_agent(rsp_agent), .rsp_rdata(rsp_rdata),
      .rsp_sc_ok(rsp_sc_ok), .mem_wr_fire(mem_wr_fire)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one request from one agent; model computed from the requirements
   task automatic do_op(input int a, input logic [1:0] op, input logic [AW-1:0] ad,
                        input logic [DW-1:0] wd, input string req, output bit ok);
      logic [DW-1:0] e_rd;
      bit e_ok, e_wr;
      @(negedge clk);
      req_valid = '0;
      req_valid[a] = 1'b1;
      req_op[2*a +: 2] = op;
      req_addr[AW*a +: AW] = ad;
      req_wdata[DW*a +: DW] = wd;
      e_rd = m_mem[ad];
      e_ok = (op == 2'd3) && m_rv[a] && (m_ra[a] == ad);
      e_wr = (op == 2'd1) || e_ok;
      if (op == 2'd2) begin m_rv[a] = 1'b1; m_ra[a] = ad; end
      if (op == 2'd3) m_rv[a] = 1'b0;
      if (e_wr) begin
         m_mem[ad] = wd;
         for (int i = 0; i < N; i++)
            if (i != a && m_rv[i] && m_ra[i] == ad) m_rv[i] = 1'b0;
      end
      @(negedge clk);
      req_valid = '0;
      chk({req, " valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " agent"}, 32'(rsp_agent), 32'(a));
      chk({req, " rdata"}, 32'(rsp_rdata), 32'(e_rd));
      chk({req, " sc_ok"}, 32'(rsp_sc_ok), 32'(e_ok));
      chk({req, " wr_fire"}, 32'(mem_wr_fire), 32'(e_wr));
      ok = rsp_sc_ok;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      bit ok;
      logic [15:0] lfsr;
      for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
      for (int i = 0; i < N; i++) begin m_rv[i] = 1'b0; m_ra[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R12 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 idle after reset", 32'(rsp_valid), 32'd0);
      chk("R12 no write after reset", 32'(mem_wr_fire), 32'd0);

      // R12: memory zero, no reservation
      for (int i = 0; i < (1<<AW); i++) do_op(0, 2'd0, AW'(i), '0, "R12 zero word", ok);
      for (int a = 0; a < N; a++) begin
         do_op(a, 2'd3, AW'(a), 16'hdead, "R8 sc without reservation", ok);
         chk("R8 sc fail no resv", 32'(ok), 32'd0);
      end

      // R1/R2 arbitration sweep over all request patterns
      for (int p = 1; p < (1<<N); p++) begin
         logic [N-1:0] e_g;
         int e_a;
         e_g = '0; e_a = 0;
         for (int i = N - 1; i >= 0; i--) if (p[i]) begin e_g = '0; e_g[i] = 1'b1; e_a = i; end
         @(negedge clk);
         req_valid = N'(p);
         for (int i = 0; i < N; i++) begin
            req_op[2*i +: 2] = 2'd0;
            req_addr[AW*i +: AW] = AW'(i);
         end
         #1;
         chk("R1 lowest index granted", 32'(req_grant), 32'(e_g));
         @(negedge clk);
         req_valid = '0;
         chk("R2 rsp_valid after grant", 32'(rsp_valid), 32'd1);
         chk("R2 rsp_agent", 32'(rsp_agent), 32'(e_a));
         #1;
         chk("R1 no grant when idle", 32'(req_grant), 32'd0);
         @(negedge clk);
         chk("R2 no rsp without grant", 32'(rsp_valid), 32'd0);
      end

      // pairwise sweeps
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (a == b) continue;
            // R3/R5: clean LL/SC
            do_op(a, 2'd2, 4'd5, '0, "R3 ll", ok);
            do_op(a, 2'd3, 4'd5, 16'(16'h100 + a), "R5 sc clean", ok);
            chk("R5 sc success", 32'(ok), 32'd1);
            do_op(b, 2'd0, 4'd5, '0, "R5 readback", ok);
            // R6: plain store by b breaks a's reservation
            do_op(a, 2'd2, 4'd6, '0, "R3 ll", ok);
            do_op(b, 2'd1, 4'd6, 16'(16'h200 + b), "R6 store by other", ok);
            do_op(a, 2'd3, 4'd6, 16'hbad0, "R6 sc after conflict", ok);
            chk("R6 sc fails", 32'(ok), 32'd0);
            do_op(b, 2'd0, 4'd6, '0, "R7 word unchanged", ok);
            // R6: successful SC by b breaks a's reservation
            do_op(a, 2'd2, 4'd7, '0, "R3 ll", ok);
            do_op(b, 2'd2, 4'd7, '0, "R3 ll other", ok);
            do_op(b, 2'd3, 4'd7, 16'(16'h300 + b), "R6 sc by other", ok);
            chk("R6 other sc ok", 32'(ok), 32'd1);
            do_op(a, 2'd3, 4'd7, 16'hbad1, "R6 sc loses", ok);
            chk("R6 sc loses", 32'(ok), 32'd0);
            // R11: unrelated activity keeps the reservation
            do_op(a, 2'd2, 4'd8, '0, "R3 ll", ok);
            do_op(b, 2'd0, 4'd8, '0, "R11 read by other", ok);
            do_op(b, 2'd2, 4'd8, '0, "R11 ll by other", ok);
            do_op(b, 2'd1, 4'd9, 16'h0099, "R11 store elsewhere", ok);
            do_op(a, 2'd1, 4'd8, 16'h0088, "R11 own store", ok);
            do_op(a, 2'd3, 4'd8, 16'(16'h400 + a), "R11 sc survives", ok);
            chk("R11 sc ok", 32'(ok), 32'd1);
            // R9: second SC fails
            do_op(a, 2'd3, 4'd8, 16'hbad2, "R9 second sc", ok);
            chk("R9 second sc fails", 32'(ok), 32'd0);
            // R8/R9: wrong-address SC fails and consumes reservation
            do_op(a, 2'd2, 4'd10, '0, "R3 ll", ok);
            do_op(a, 2'd3, 4'd11, 16'hbad3, "R8 sc wrong addr", ok);
            chk("R8 wrong addr fails", 32'(ok), 32'd0);
            do_op(a, 2'd3, 4'd10, 16'hbad4, "R9 resv consumed", ok);
            chk("R9 after failed sc", 32'(ok), 32'd0);
            // R10: new LL replaces old
            do_op(a, 2'd2, 4'd12, '0, "R10 ll first", ok);
            do_op(a, 2'd2, 4'd13, '0, "R10 ll second", ok);
            do_op(a, 2'd3, 4'd12, 16'hbad5, "R10 old addr", ok);
            chk("R10 old addr fails", 32'(ok), 32'd0);
            do_op(a, 2'd2, 4'd12, '0, "R10 ll first", ok);
            do_op(a, 2'd2, 4'd13, '0, "R10 ll second", ok);
            do_op(a, 2'd3, 4'd13, 16'(16'h500 + a), "R10 new addr", ok);
            chk("R10 new addr ok", 32'(ok), 32'd1);
         end
      end

      // mixed sequence over a narrow address range, model-checked
      lfsr = 16'hace1;
      for (int k = 0; k < 600; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         do_op(int'(lfsr[1:0]), lfsr[3:2], AW'(lfsr[5:4]), lfsr ^ 16'h5a5a,
               "R13 mixed sequence", ok);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule